// File: doc/BRIEF.md
# Fused multiply-add NaN selector

This block handles the special-value side of single-precision arithmetic. It looks at the operands of a fused multiply-add (a*b+c), or at the first two operands of a two-operand operation, and decides whether the result must be a NaN. If so, it chooses which operand supplies that NaN, or whether the default quiet NaN is used. It also sets the invalid-operation flag and an infinity-times-zero sub-flag. The multiply, add and rounding datapath sits beside it and is not part of this block. When `nan_path` is low after a strobe, the normal datapath result is the one to use.

Each operand is classified once by its own classifier. A combinational priority selector picks a source, and a former quiets the chosen word. A two-state machine captures the verdict on `in_valid` and shows it one clock later. States: `ST_EMPTY` (nothing captured, all outputs zero) and `ST_HELD` (the last verdict is shown). Transitions: a synchronous reset goes to `ST_EMPTY`, `ST_EMPTY` goes to `ST_HELD` on `in_valid`, and `ST_HELD` stays in `ST_HELD`, reloading on each `in_valid`.

Top module: `fma_nan_pick`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. A NaN with bit 22 at 1 is quiet, and with bit 22 at 0 it is signaling. The exponent all ones with a zero fraction is infinity. Bits 30:0 all zero is zero, and a denormal is not zero.
- R2: In FMA mode (`fma_mode`=1), one multiplicand infinite and the other zero sets `flag_invalid`, `flag_imz` and `nan_path`. If c is a NaN, the result is c made quiet.
- R3: The infinity-times-zero case of R2 with a c that is not a NaN gives 0x7FC00000.
- R4: In FMA mode without infinity-times-zero, a signaling NaN beats any quiet NaN, and signaling NaNs are tried in the order c, a, b.
- R5: In FMA mode with no signaling NaN, quiet NaNs are tried in the order c, a, b.
- R6: In two-operand mode (`fma_mode`=0) the order is a if signaling, b if signaling, a if quiet, b if quiet. Operand c is ignored, and `flag_imz` is never set.
- R7: A NaN result is the selected operand with bit 22 forced to 1, keeping its sign and all other payload bits.
- R8: `flag_invalid` is set when any considered operand is a signaling NaN, or in the infinity-times-zero case. Quiet NaNs alone set no flag.
- R9: With no considered NaN and no infinity-times-zero case, `nan_path`, both flags and `res_word` are all 0.
- R10: Outputs change only one clock after a cycle with `in_valid` high, and hold while `in_valid` is low, whatever the operands do.
- R11: A synchronous reset clears `res_word`, `nan_path` and both flags from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| fma_mode | input | 1 | 1: three-operand FMA, 0: two-operand |
| op_a | input | 32 | Operand a (multiplicand) |
| op_b | input | 32 | Operand b (multiplicand) |
| op_c | input | 32 | Operand c (addend) |
| res_word | output | 32 | Selected quiet NaN, or 0 |
| nan_path | output | 1 | NaN result required |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_imz | output | 1 | Infinity-times-zero sub-flag |

## Verification
A machine stuck in `ST_EMPTY` shows all zeros in the cycle after a strobe that should produce a NaN. A machine that never leaves `ST_HELD` after reset shows stale data in the first cycle after reset. A wrong priority or a wrong quieting shows up as a wrong payload or sign on `res_word` exactly one clock after the strobe. A missed capture or a spurious reload shows as a changed output on any idle cycle while the operands are scrambled.

// File: rtl/fnan_pkg.sv
package fnan_pkg;

    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;

    typedef enum logic [2:0] {
        CL_NUM,
        CL_ZERO,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } opclass_t;

    typedef enum logic [1:0] {
        SRC_A,
        SRC_B,
        SRC_C,
        SRC_DFLT
    } src_t;

    typedef enum logic {
        ST_EMPTY,
        ST_HELD
    } state_t;

    typedef struct packed {
        logic take_nan;
        src_t src;
        logic invalid;
        logic imz;
    } verdict_t;

    function automatic logic is_nan(opclass_t c);
        return (c == CL_QNAN) || (c == CL_SNAN);
    endfunction

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
    import fnan_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int MAG_W = EXP_W + FRAC_W,
    localparam int QBIT  = FRAC_W - 1
) (
    input  logic [MAG_W-1:0] mag,
    output opclass_t         cls
);

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;

    assign expo = mag[MAG_W-1:FRAC_W];
    assign frac = mag[FRAC_W-1:0];

    always_comb begin
        if (&expo) begin
            if (frac == '0)
                cls = CL_INF;
            else if (frac[QBIT])
                cls = CL_QNAN;
            else
                cls = CL_SNAN;
        end else if (mag == '0) begin
            cls = CL_ZERO;
        end else begin
            cls = CL_NUM;
        end
    end

endmodule

// File: rtl/fnan_select.sv
module fnan_select
    import fnan_pkg::*;
(
    input  opclass_t cls_a,
    input  opclass_t cls_b,
    input  opclass_t cls_c,
    input  logic     fma_mode,
    output verdict_t v
);

    logic imz_hit;

    always_comb begin
        imz_hit = ((cls_a == CL_INF)  && (cls_b == CL_ZERO)) ||
                  ((cls_a == CL_ZERO) && (cls_b == CL_INF));
        v.take_nan = 1'b1;
        v.src      = SRC_A;
        v.invalid  = 1'b0;
        v.imz      = 1'b0;
        if (fma_mode) begin
            v.invalid = (cls_a == CL_SNAN) || (cls_b == CL_SNAN) ||
                        (cls_c == CL_SNAN);
            if (imz_hit) begin
                v.invalid = 1'b1;
                v.imz     = 1'b1;
                v.src     = is_nan(cls_c) ? SRC_C : SRC_DFLT;
            end else if (cls_c == CL_SNAN) v.src = SRC_C;
            else if (cls_a == CL_SNAN)     v.src = SRC_A;
            else if (cls_b == CL_SNAN)     v.src = SRC_B;
            else if (cls_c == CL_QNAN)     v.src = SRC_C;
            else if (cls_a == CL_QNAN)     v.src = SRC_A;
            else if (cls_b == CL_QNAN)     v.src = SRC_B;
            else                           v.take_nan = 1'b0;
        end else begin
            v.invalid = (cls_a == CL_SNAN) || (cls_b == CL_SNAN);
            if (cls_a == CL_SNAN)      v.src = SRC_A;
            else if (cls_b == CL_SNAN) v.src = SRC_B;
            else if (cls_a == CL_QNAN) v.src = SRC_A;
            else if (cls_b == CL_QNAN) v.src = SRC_B;
            else                       v.take_nan = 1'b0;
        end
    end

endmodule

// File: rtl/fnan_form.sv
module fnan_form
    import fnan_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int QBIT  = FRAC_W - 1
) (
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    input  logic [W-1:0] word_c,
    input  verdict_t     v,
    output logic [W-1:0] word_out
);

    localparam logic [W-1:0] DFLT_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0] pick;

    always_comb begin
        unique case (v.src)
            SRC_A:    pick = word_a;
            SRC_B:    pick = word_b;
            SRC_C:    pick = word_c;
            SRC_DFLT: pick = DFLT_NAN;
        endcase
        pick[QBIT] = 1'b1;
        word_out   = v.take_nan ? pick : '0;
    end

endmodule

// File: rtl/fma_nan_pick.sv
module fma_nan_pick
    import fnan_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic         fma_mode,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    output logic [W-1:0] res_word,
    output logic         nan_path,
    output logic         flag_invalid,
    output logic         flag_imz
);

    localparam int NOPS  = 3;
    localparam int MAG_W = W - 1;

    logic [NOPS-1:0][MAG_W-1:0] mags;
    opclass_t                   cls [NOPS];
    verdict_t                   verdict;
    logic [W-1:0]               formed;

    state_t       state, nxt;
    logic [W-1:0] hold_word;
    logic         hold_np, hold_inv, hold_imz;

    assign mags = {op_c[MAG_W-1:0], op_b[MAG_W-1:0], op_a[MAG_W-1:0]};

    for (genvar i = 0; i < NOPS; i++) begin : g_cls
        fnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .mag (mags[i]),
            .cls (cls[i])
        );
    end

    fnan_select u_sel (
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .cls_c    (cls[2]),
        .fma_mode (fma_mode),
        .v        (verdict)
    );

    fnan_form #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_form (
        .word_a   (op_a),
        .word_b   (op_b),
        .word_c   (op_c),
        .v        (verdict),
        .word_out (formed)
    );

    // next-state logic
    always_comb begin
        unique case (state)
            ST_EMPTY: nxt = in_valid ? ST_HELD : ST_EMPTY;
            ST_HELD:  nxt = ST_HELD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_EMPTY;
        else
            state <= nxt;
    end

    // capture registers: hidden by ST_EMPTY, so no reset needed
    always_ff @(posedge clk) begin
        if (in_valid) begin
            hold_word <= formed;
            hold_np   <= verdict.take_nan;
            hold_inv  <= verdict.invalid;
            hold_imz  <= verdict.imz;
        end
    end

    // outputs by state
    always_comb begin
        unique case (state)
            ST_EMPTY: begin
                res_word     = '0;
                nan_path     = 1'b0;
                flag_invalid = 1'b0;
                flag_imz     = 1'b0;
            end
            ST_HELD: begin
                res_word     = hold_word;
                nan_path     = hold_np;
                flag_invalid = hold_inv;
                flag_imz     = hold_imz;
            end
        endcase
    end

endmodule

// File: rtl/fnan_chk.sv
module fnan_chk
    import fnan_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int QBIT  = FRAC_W - 1
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         fma_mode,
    input logic [W-1:0] res_word,
    input logic         nan_path,
    input logic         flag_invalid,
    input logic         flag_imz
);

    logic armed;

    always_ff @(posedge clk) armed <= !rst;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !$past(in_valid) |-> ($stable(res_word) && $stable(nan_path) &&
                              $stable(flag_invalid) && $stable(flag_imz)));

    // R9
    no_nan_clear_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        !nan_path |-> (res_word == '0 && !flag_invalid && !flag_imz));

    // R7
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        nan_path |-> (&res_word[W-2:QBIT]));

    // R2
    imz_invalid_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        flag_imz |-> (flag_invalid && nan_path));

    // R6
    two_op_imz_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($past(in_valid) && !$past(fma_mode)) |-> !flag_imz);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (res_word == '0 && !nan_path && !flag_invalid && !flag_imz));

endmodule

bind fma_nan_pick fnan_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .fma_mode     (fma_mode),
    .res_word     (res_word),
    .nan_path     (nan_path),
    .flag_invalid (flag_invalid),
    .flag_imz     (flag_imz)
);

// File: tb/test_fma_nan_pick.sv
module test_fma_nan_pick;

    localparam logic [31:0] QMASK = 32'h0040_0000;
    localparam logic [31:0] DNAN  = 32'h7FC0_0000;

    localparam logic [31:0] SA = 32'h7F80_0001, SB = 32'hFF81_2345, SC = 32'h7FA0_0000;
    localparam logic [31:0] QA = 32'h7FC0_0011, QB = 32'hFFC0_0022, QC = 32'h7FE0_0033;
    localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
    localparam logic [31:0] PZ = 32'h0, NZ = 32'h8000_0000;
    localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000, DEN = 32'h0000_0001;

    typedef struct {
        logic [31:0] w;
        logic        np;
        logic        inv;
        logic        imz;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        fma_mode = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic [31:0] res_word;
    logic        nan_path, flag_invalid, flag_imz;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t sb[$];
    exp_t last;
    bit   have_last = 0;

    always #4 clk = ~clk;

    fma_nan_pick i_fma_nan_pick (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .fma_mode     (fma_mode),
        .op_a         (op_a),
        .op_b         (op_b),
        .op_c         (op_c),
        .res_word     (res_word),
        .nan_path     (nan_path),
        .flag_invalid (flag_invalid),
        .flag_imz     (flag_imz)
    );

    // 0 number, 1 zero, 2 infinity, 3 quiet NaN, 4 signaling NaN
    function automatic int kind(logic [31:0] x);
        if (x[30:23] == 8'hFF) begin
            if (x[22:0] == 0) return 2;
            return x[22] ? 3 : 4;
        end
        if (x[30:0] == 0) return 1;
        return 0;
    endfunction

    function automatic exp_t model(bit fma, logic [31:0] a, logic [31:0] b, logic [31:0] c);
        exp_t r;
        int ka = kind(a), kb = kind(b), kc = kind(c);
        r.w = '0; r.np = 0; r.inv = 0; r.imz = 0; r.tag = "";
        if (fma) begin
            if ((ka == 2 && kb == 1) || (ka == 1 && kb == 2)) begin
                r.np = 1; r.inv = 1; r.imz = 1;
                r.w  = (kc >= 3) ? (c | QMASK) : DNAN;
                return r;
            end
            r.inv = (ka == 4) || (kb == 4) || (kc == 4);
            r.np  = 1;
            if (kc == 4)      r.w = c | QMASK;
            else if (ka == 4) r.w = a | QMASK;
            else if (kb == 4) r.w = b | QMASK;
            else if (kc == 3) r.w = c | QMASK;
            else if (ka == 3) r.w = a | QMASK;
            else if (kb == 3) r.w = b | QMASK;
            else              r.np = 0;
        end else begin
            r.inv = (ka == 4) || (kb == 4);
            r.np  = 1;
            if (ka == 4)      r.w = a | QMASK;
            else if (kb == 4) r.w = b | QMASK;
            else if (ka == 3) r.w = a | QMASK;
            else if (kb == 3) r.w = b | QMASK;
            else              r.np = 0;
        end
        return r;
    endfunction

    function automatic exp_t zero_item(string tag);
        exp_t r;
        r.w = '0; r.np = 0; r.inv = 0; r.imz = 0; r.tag = tag;
        return r;
    endfunction

    task automatic check(exp_t e);
        n_checks++;
        if (res_word !== e.w || nan_path !== e.np || flag_invalid !== e.inv || flag_imz !== e.imz) begin
            n_fails++;
            $display("FAIL %s: got word=%h np=%b inv=%b imz=%b, expected word=%h np=%b inv=%b imz=%b",
                     e.tag, res_word, nan_path, flag_invalid, flag_imz, e.w, e.np, e.inv, e.imz);
        end
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic drive(bit fma, logic [31:0] a, logic [31:0] b, logic [31:0] c,
                         string tag, int idle);
        exp_t e;
        fma_mode = fma; op_a = a; op_b = b; op_c = c; in_valid = 1'b1;
        e = model(fma, a, b, c);
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        op_a = $urandom; op_b = $urandom; op_c = $urandom; fma_mode = 1'($urandom);
        repeat (idle) @(negedge clk);
    endtask

    // monitor: compare each captured strobe, and the hold on idle cycles
    initial begin
        bit pend, rs;
        exp_t e;
        forever begin
            @(posedge clk);
            pend = in_valid;
            rs   = rst;
            @(negedge clk);
            if (rs) begin
                last = zero_item("R11 reset clear");
                have_last = 1;
            end else if (pend) begin
                if (sb.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL R10: result with empty scoreboard, got word=%h expected none", res_word);
                end else begin
                    e = sb.pop_front();
                    check(e);
                    last = e;
                    last.tag = {e.tag, " / R10 hold"};
                    have_last = 1;
                end
            end else if (have_last) begin
                check(last);
            end
        end
    end

    initial begin
        #(8 * 50000);
        n_fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(zero_item("R11 after reset"));

        // R9, R1: ordinary numbers, infinities, denormal are not NaN
        drive(1, ONE, TWO, ONE,   "R9 plain numbers", 2);
        drive(1, PINF, ONE, NINF, "R1 infinity is not NaN", 1);
        drive(1, DEN, PINF, ONE,  "R1 denormal is not zero", 1);
        drive(1, ONE, ONE, DNAN,  "R1 payload-only quiet bit is qNaN", 1);
        // R2, R3 infinity times zero
        drive(1, PINF, PZ, QC,    "R2 inf*0 with qNaN c", 2);
        drive(1, NZ, NINF, SC,    "R2 0*inf with sNaN c", 1);
        drive(1, PINF, NZ, ONE,   "R3 inf*0 default NaN", 1);
        // R4 signaling priority c, a, b
        drive(1, SA, SB, SC,      "R4 all signaling picks c", 1);
        drive(1, QA, SB, QC,      "R4 sNaN b beats qNaN c", 1);
        drive(1, SA, SB, ONE,     "R4 sNaN a before b", 0);
        drive(1, ONE, SB, QC,     "R4 only b signaling", 1);
        // R5, R8 quiet priority c, a, b; no flag
        drive(1, QA, QB, QC,      "R5 quiet picks c", 0);
        drive(1, QA, QB, ONE,     "R5 quiet a before b", 0);
        drive(1, ONE, QB, TWO,    "R8 lone qNaN b no flag", 2);
        // R6 two-operand order, c ignored
        drive(0, QA, SB, SC,      "R6 sNaN b beats qNaN a", 1);
        drive(0, SA, SB, QC,      "R6 sNaN a first", 1);
        drive(0, QA, QB, SC,      "R6 qNaN a, c ignored", 1);
        drive(0, ONE, QB, SC,     "R6 qNaN b no flag", 1);
        drive(0, PINF, PZ, QC,    "R6 no inf*0 in two-operand", 2);
        // R7 negative payload preserved
        drive(1, NZ, ONE, 32'hFF80_ABCD, "R7 sign and payload kept", 3);

        // R11 reset in the middle, then reuse
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(zero_item("R11 mid-run reset"));
        drive(1, SA, QB, ONE,     "R4 after reset", 2);

        repeat (3) @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fails++;
            $display("FAIL R10: %0d results never appeared, expected 0", sb.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule